// File: doc/BRIEF.md
# External Interrupt Sense Controller

This block watches four external interrupt pins and turns their activity into per-pin interrupt requests for a processor. Each pin has its own 2-bit sense mode: low level, any change, falling edge or rising edge. Raw pin values first pass through a synchronizer on the system clock. Edges are then found by comparing each synchronized sample with the one from the cycle before. Edge and change events set a sticky per-pin flag, which software clears with a per-pin acknowledge. Low-level mode has no flag. Its request simply follows the pin and holds for as long as the pin stays low.

A request leaves the block only when the pin's mask bit and the global interrupt-enable input are both one. Flags still latch while a pin is masked, so an event that happens while the pin is masked is delivered once the mask opens. Requests come from the pin value alone, so logic that drives a pin (including a pin used as an output) can raise a request deliberately. Software programs the modes and the mask through a small two-register write/read port. Rewriting a pin's mode never produces a request by itself.

Top module: `ext_irq_sense`

## Requirements
- R1: After reset, the sense register (address 0) and the mask register (address 1) both read 0x00 and `irqReq` is all zeros.
- R2: The sense register is written and read at `regAddr`=0. Pin n's mode occupies bits 2n+1:2n, with the encodings 00 = low level, 01 = any change, 10 = falling edge, 11 = rising edge.
- R3: The mask register sits at `regAddr`=1 and holds one enable per pin in bits 3:0. Bits 7:4 ignore writes and always read as zero.
- R4: `irqReq[n]` can be 1 only when mask bit n and `globalEn` are both 1. A change in either input reaches `irqReq` in the same cycle.
- R5: In mode 00, `irqReq[n]` is high exactly while the synchronized pin is low. It rises on the second clock edge after the pin falls and drops on the second edge after the pin rises.
- R6: In mode 01, any change of the pin sets the pin's flag. The request appears after the third clock edge following the change.
- R7: In mode 10, a falling pin sets the flag and a rising pin does not.
- R8: In mode 11, a rising pin sets the flag and a falling pin does not.
- R9: A flag stays set until `ackIn[n]` is high at a clock edge. If a new event is detected at the same edge as the acknowledge, the flag stays set.
- R10: A flag latches while its mask bit is 0. The request appears as soon as the mask bit is set.
- R11: When a write changes a pin's mode field, a pin transition that reaches the synchronizer output at that same edge is not reported. Later transitions are reported normally.
- R12: In an edge or change mode, a pin pulse held across one rising clock edge is reported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| pinIn | input | 4 | Raw external interrupt pins |
| globalEn | input | 1 | Global interrupt enable from the processor |
| ackIn | input | 4 | Per-pin flag clear, sampled on the clock |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 1 | Register select: 0 sense, 1 mask |
| regWrData | input | 8 | Register write data |
| regRdData | output | 8 | Read data of the selected register |
| irqReq | output | 4 | Per-pin interrupt requests |

## Verification
The bench goes through every pin, every mode and both edge directions. If a mode field were decoded from the wrong bits, or a mode answered the wrong edge, the wrong bit of `irqReq` would rise. It targets the edge where an acknowledge and a new event coincide; a design that gives the clear priority would lose that second interrupt. It also makes the synchronized pin change at the same edge where its mode is rewritten; a design without the sample reload would raise a spurious rising-edge request there. Single-cycle pulses, the exact level and edge latencies, and events that arrive while a pin is masked are checked as well. A design that dropped short pulses, added or lost a register stage, or discarded masked events would miss a request or present it one cycle early or late.

// File: rtl/irq_sense_pkg.sv
package irq_sense_pkg;
  localparam int PIN_COUNT  = 4;
  localparam int SENSE_W    = 2;
  localparam int SENSE_BITS = PIN_COUNT * SENSE_W;
  localparam int REG_W      = 8;

  localparam logic ADDR_SENSE = 1'b0;
  localparam logic ADDR_MASK  = 1'b1;

  typedef enum logic [SENSE_W-1:0] {
    SENSE_LOW  = 2'b00,
    SENSE_ANY  = 2'b01,
    SENSE_FALL = 2'b10,
    SENSE_RISE = 2'b11
  } senseMode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic [PIN_COUNT-1:0] reload;  // mode field changed: resync previous sample
    logic [PIN_COUNT-1:0] gate;    // mask and global enable combined
  } ctrlStrobe_t;
endpackage

// File: rtl/irq_sense_ctrl.sv
module irq_sense_ctrl
  import irq_sense_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  regWrEn,
  input  logic                  regAddr,
  input  logic [REG_W-1:0]      regWrData,
  input  logic                  globalEn,
  output logic [REG_W-1:0]      regRdData,
  output logic [SENSE_BITS-1:0] senseReg,
  output logic [PIN_COUNT-1:0]  maskReg,
  output ctrlStrobe_t           strobe
);
  logic senseWrite;
  logic maskWrite;

  assign senseWrite = regWrEn && (regAddr == ADDR_SENSE);
  assign maskWrite  = regWrEn && (regAddr == ADDR_MASK);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      senseReg <= '0;
      maskReg  <= '0;
    end else begin
      if (senseWrite) senseReg <= regWrData[SENSE_BITS-1:0];
      if (maskWrite)  maskReg  <= regWrData[PIN_COUNT-1:0];
    end
  end

  for (genvar n = 0; n < PIN_COUNT; n++) begin : g_strobe
    assign strobe.reload[n] = senseWrite &&
      (regWrData[n*SENSE_W +: SENSE_W] != senseReg[n*SENSE_W +: SENSE_W]);
    assign strobe.gate[n] = maskReg[n] & globalEn;
  end

  always_comb begin
    regRdData = '0;
    if (regAddr == ADDR_SENSE) regRdData[SENSE_BITS-1:0] = senseReg;
    else                       regRdData[PIN_COUNT-1:0]  = maskReg;
  end
endmodule

// File: rtl/irq_sense_dp.sv
module irq_sense_dp
  import irq_sense_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [PIN_COUNT-1:0]  pinIn,
  input  logic [PIN_COUNT-1:0]  ackIn,
  input  logic [SENSE_BITS-1:0] senseReg,
  input  ctrlStrobe_t           strobe,
  output logic [PIN_COUNT-1:0]  syncVal,
  output logic [PIN_COUNT-1:0]  flagQ,
  output logic [PIN_COUNT-1:0]  irqReq
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [PIN_COUNT-1:0] stageQ [SYNC_STAGES];
  logic [PIN_COUNT-1:0] prevQ;
  logic [PIN_COUNT-1:0] nextSync;
  logic [PIN_COUNT-1:0] eventHit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < SYNC_STAGES; i++) stageQ[i] <= '0;
    end else begin
      stageQ[0] <= pinIn;
      for (int i = 1; i < SYNC_STAGES; i++) stageQ[i] <= stageQ[i-1];
    end
  end

  assign syncVal  = stageQ[LAST];
  assign nextSync = stageQ[LAST-1];

  for (genvar n = 0; n < PIN_COUNT; n++) begin : g_pin
    senseMode_e mode;
    logic riseEv;
    logic fallEv;

    assign mode   = senseMode_e'(senseReg[n*SENSE_W +: SENSE_W]);
    assign riseEv = syncVal[n] & ~prevQ[n];
    assign fallEv = ~syncVal[n] & prevQ[n];

    always_comb begin
      unique case (mode)
        SENSE_LOW:  eventHit[n] = 1'b0;
        SENSE_ANY:  eventHit[n] = riseEv | fallEv;
        SENSE_FALL: eventHit[n] = fallEv;
        SENSE_RISE: eventHit[n] = riseEv;
      endcase
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        prevQ[n] <= 1'b0;
        flagQ[n] <= 1'b0;
      end else begin
        prevQ[n] <= strobe.reload[n] ? nextSync[n] : syncVal[n];
        flagQ[n] <= (flagQ[n] & ~ackIn[n]) | eventHit[n];
      end
    end

    assign irqReq[n] = strobe.gate[n] &
                       ((mode == SENSE_LOW) ? ~syncVal[n] : flagQ[n]);
  end
endmodule

// File: rtl/ext_irq_sense.sv
module ext_irq_sense
  import irq_sense_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [PIN_COUNT-1:0] pinIn,
  input  logic                 globalEn,
  input  logic [PIN_COUNT-1:0] ackIn,
  input  logic                 regWrEn,
  input  logic                 regAddr,
  input  logic [REG_W-1:0]     regWrData,
  output logic [REG_W-1:0]     regRdData,
  output logic [PIN_COUNT-1:0] irqReq
);
  logic [SENSE_BITS-1:0] senseReg;
  logic [PIN_COUNT-1:0]  maskReg;
  logic [PIN_COUNT-1:0]  syncVal;
  logic [PIN_COUNT-1:0]  flagQ;
  ctrlStrobe_t           strobe;

  irq_sense_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .globalEn(globalEn), .regRdData(regRdData),
    .senseReg(senseReg), .maskReg(maskReg), .strobe(strobe)
  );

  irq_sense_dp #(.SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk(clk), .rstN(rstN), .pinIn(pinIn), .ackIn(ackIn),
    .senseReg(senseReg), .strobe(strobe), .syncVal(syncVal),
    .flagQ(flagQ), .irqReq(irqReq)
  );
endmodule

// File: rtl/irq_sense_chk.sv
module irq_sense_chk
  import irq_sense_pkg::*;
(
  input logic                  clk,
  input logic                  rstN,
  input logic                  globalEn,
  input logic [PIN_COUNT-1:0]  ackIn,
  input logic                  regAddr,
  input logic [REG_W-1:0]      regRdData,
  input logic [PIN_COUNT-1:0]  irqReq,
  input logic [SENSE_BITS-1:0] senseReg,
  input logic [PIN_COUNT-1:0]  maskReg,
  input logic [PIN_COUNT-1:0]  syncVal,
  input logic [PIN_COUNT-1:0]  flagQ
);
  p_rsvd_zero_r3: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == ADDR_MASK) |-> (regRdData[REG_W-1:PIN_COUNT] == '0));

  p_gated_r4: assert property (@(posedge clk) disable iff (!rstN)
    (irqReq & ~(maskReg & {PIN_COUNT{globalEn}})) == '0);

  for (genvar n = 0; n < PIN_COUNT; n++) begin : g_pin
    p_level_r5: assert property (@(posedge clk) disable iff (!rstN)
      (senseReg[n*SENSE_W +: SENSE_W] == SENSE_LOW && maskReg[n] && globalEn
       && !syncVal[n]) |-> irqReq[n]);

    p_flag_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
      (flagQ[n] && !ackIn[n]) |=> flagQ[n]);

    p_fall_r7: assert property (@(posedge clk) disable iff (!rstN)
      (senseReg[n*SENSE_W +: SENSE_W] == SENSE_FALL
       && $stable(senseReg[n*SENSE_W +: SENSE_W]) && $fell(syncVal[n])) |=> flagQ[n]);

    p_rise_r8: assert property (@(posedge clk) disable iff (!rstN)
      (senseReg[n*SENSE_W +: SENSE_W] == SENSE_RISE
       && $stable(senseReg[n*SENSE_W +: SENSE_W]) && $rose(syncVal[n])) |=> flagQ[n]);
  end
endmodule

bind ext_irq_sense irq_sense_chk u_chk (
  .clk(clk), .rstN(rstN), .globalEn(globalEn), .ackIn(ackIn),
  .regAddr(regAddr), .regRdData(regRdData), .irqReq(irqReq),
  .senseReg(senseReg), .maskReg(maskReg), .syncVal(syncVal), .flagQ(flagQ)
);

// File: tb/tb_ext_irq_sense.sv
module tb_ext_irq_sense;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN;
  logic [3:0] pinIn;
  logic       globalEn;
  logic [3:0] ackIn;
  logic       regWrEn;
  logic       regAddr;
  logic [7:0] regWrData;
  logic [7:0] regRdData;
  logic [3:0] irqReq;

  int checks   = 0;
  int failures = 0;
  bit done     = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ext_irq_sense dut (
    .clk(clk), .rstN(rstN), .pinIn(pinIn), .globalEn(globalEn), .ackIn(ackIn),
    .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
    .regRdData(regRdData), .irqReq(irqReq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int k);
    repeat (k) @(negedge clk);
  endtask

  task automatic wrReg(input logic a, input logic [7:0] d);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    cyc(1);
    regWrEn = 1'b0;
  endtask

  task automatic rdReg(input logic a, output logic [7:0] d);
    regAddr = a;
    #1 d = regRdData;
  endtask

  task automatic ackAll();
    ackIn = 4'hF; cyc(1); ackIn = 4'h0;
  endtask

  function automatic logic [7:0] senseWith(input int n, input int m);
    logic [7:0] v;
    v = 8'hFF;
    v[2*n +: 2] = m[1:0];
    return v;
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [7:0] rd;
    rstN = 1'b0; pinIn = '0; globalEn = 1'b0; ackIn = '0;
    regWrEn = 1'b0; regAddr = 1'b0; regWrData = '0;
    cyc(3);
    rstN = 1'b1;
    cyc(1);

    // R1 reset state
    #1 chk("R1 irqReq", irqReq, 0);
    rdReg(0, rd); chk("R1 sense reg", rd, 8'h00);
    rdReg(1, rd); chk("R1 mask reg", rd, 8'h00);

    // R2 sense readback, R3 reserved mask bits
    wrReg(0, 8'hB4);
    rdReg(0, rd); chk("R2 sense readback", rd, 8'hB4);
    wrReg(1, 8'hF5);
    rdReg(1, rd); chk("R3 mask reserved bits", rd, 8'h05);

    wrReg(1, 8'h0F);
    globalEn = 1'b1;

    // R2/R5/R6/R7/R8 sweep: every pin, mode, direction
    for (int n = 0; n < 4; n++) begin
      for (int m = 0; m < 4; m++) begin
        for (int dir = 0; dir < 2; dir++) begin
          logic [3:0] exp;
          logic hit;
          pinIn = '0;
          pinIn[n] = (dir == 1);
          cyc(3);
          wrReg(0, senseWith(n, m));
          cyc(3);
          ackAll();
          pinIn[n] = (dir == 0);
          cyc(3);
          case (m)
            0: hit = (dir == 1);
            1: hit = 1'b1;
            2: hit = (dir == 1);
            default: hit = (dir == 0);
          endcase
          exp = '0;
          exp[n] = hit;
          #1;
          case (m)
            0: chk($sformatf("R5 level pin%0d dir%0d", n, dir), irqReq, exp);
            1: chk($sformatf("R6 change pin%0d dir%0d", n, dir), irqReq, exp);
            2: chk($sformatf("R7 fall pin%0d dir%0d", n, dir), irqReq, exp);
            default: chk($sformatf("R8 rise pin%0d dir%0d", n, dir), irqReq, exp);
          endcase
          if (m != 0 && hit) begin
            ackIn[n] = 1'b1; cyc(1); ackIn = '0;
            #1 chk($sformatf("R9 ack clears pin%0d", n), irqReq, 0);
          end
        end
      end
    end

    // R5 level latency, pin 0
    pinIn = 4'h1; wrReg(0, 8'hFC); cyc(3); ackAll();
    pinIn[0] = 1'b0;
    cyc(1); #1 chk("R5 level not yet", irqReq, 0);
    cyc(1); #1 chk("R5 level after 2 edges", irqReq, 4'h1);
    pinIn[0] = 1'b1;
    cyc(1); #1 chk("R5 level holds 1 edge", irqReq, 4'h1);
    cyc(1); #1 chk("R5 level drops", irqReq, 0);

    // R6 edge latency, pin 1
    pinIn = '0; wrReg(0, 8'hF7); cyc(3); ackAll();
    pinIn[1] = 1'b1;
    cyc(2); #1 chk("R6 change not yet", irqReq, 0);
    cyc(1); #1 chk("R6 change after 3 edges", irqReq, 4'h2);

    // R4 global enable and mask gating (pin 1 flag pending)
    globalEn = 1'b0; #1 chk("R4 globalEn low", irqReq, 0);
    globalEn = 1'b1; #1 chk("R4 globalEn high", irqReq, 4'h2);
    wrReg(1, 8'h00); #1 chk("R4 mask off", irqReq, 0);
    wrReg(1, 8'h0F); #1 chk("R4 mask on", irqReq, 4'h2);

    // R10 latch while masked
    ackAll(); wrReg(1, 8'h00);
    pinIn[1] = 1'b0; cyc(3);
    #1 chk("R10 masked no request", irqReq, 0);
    wrReg(1, 8'h0F);
    #1 chk("R10 request after unmask", irqReq, 4'h2);

    // R9 ack and event in the same cycle
    pinIn[1] = 1'b1;
    cyc(2);
    ackIn[1] = 1'b1; cyc(1); ackIn = '0;
    #1 chk("R9 event beats ack", irqReq, 4'h2);
    ackIn[1] = 1'b1; cyc(1); ackIn = '0;
    #1 chk("R9 plain ack", irqReq, 0);

    // R12 one-cycle pulses
    pinIn = 4'h8; wrReg(0, 8'hBF); cyc(3); ackAll();
    pinIn[2] = 1'b1; cyc(1); pinIn[2] = 1'b0;
    cyc(3); #1 chk("R12 high pulse rising mode", irqReq, 4'h4);
    ackAll();
    pinIn[3] = 1'b0; cyc(1); pinIn[3] = 1'b1;
    cyc(3); #1 chk("R12 low pulse falling mode", irqReq, 4'h8);

    // R11 mode rewrite coinciding with a synced transition
    pinIn = '0; wrReg(0, 8'hFE); cyc(3); ackAll();
    pinIn[0] = 1'b1; cyc(1);
    wrReg(0, 8'hFF);
    cyc(3); #1 chk("R11 no spurious edge", irqReq, 0);
    pinIn[0] = 1'b0; cyc(3);
    pinIn[0] = 1'b1; cyc(3);
    #1 chk("R11 later edge reported", irqReq, 4'h1);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule